// File: doc/BRIEF.md
# DMA Channel Interrupt Collector

This block gathers completion events from a set of DMA channels (sixteen by default) and reduces them to a single interrupt line. Each channel raises one-cycle pulses for three kinds of event:

- half of a transfer moved;
- one descriptor finished;
- the whole descriptor chain finished.

Every pulse latches a sticky pending bit. A matching enable bit decides whether that pending bit contributes to the interrupt.

Software reaches the block through a single-cycle register port. Writes take effect on the clock edge. Reads are combinational from the address.

Each channel owns a 4-bit nibble, and one 32-bit word holds eight channels. There are two enable words and two pending words. Pending bits are cleared by writing ones to them, so an interrupt handler can write back the value it read and acknowledge exactly what it saw.

Top module: `dma_irq_collect`

## Requirements
- R1: Channel n is held in word n/8 of its register kind, at bit offset 4*(n mod 8).
- R2: Within a nibble, bit 0 is the half-transfer event, bit 1 is descriptor done and bit 2 is chain done.
- R3: Enable words sit at addresses 0x00 (channels 0-7) and 0x04 (channels 8-15). They read back exactly what was last written to bits 0-2 of each nibble.
- R4: Pending words sit at 0x10 and 0x14 with the same layout as the enable words. A pending bit is set one cycle after its event pulse, whatever the enable bit holds.
- R5: A write to a pending word clears exactly the bits written as one; every other pending bit keeps its value.
- R6: When an event pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R7: Bit 3 of every nibble reads as zero in all four words and ignores writes.
- R8: The irq output is registered: in each cycle it equals the OR, over all bits, of pending AND enable as they stood in the previous cycle. With both enable words written to zero, irq is low one cycle later.
- R9: Writing zeros to a pending word never sets a bit. Writes to unmapped addresses change nothing, and reads of them return zero.
- R10: After reset, all enable and pending bits and irq are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Byte address for reads and writes |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for reg_addr |
| ev_half | input | NUM_CH (16) | Per-channel half-transfer pulse |
| ev_desc | input | NUM_CH (16) | Per-channel descriptor-done pulse |
| ev_list | input | NUM_CH (16) | Per-channel chain-done pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions check the following on every cycle:

- pending bits rise only after a matching event;
- every pending event lands in its bit;
- pending bits fall only after a write to a pending word;
- enable bits change only after a write to an enable word;
- the reserved nibble bit always reads zero;
- irq tracks the previous cycle's pending-and-enable product.

Some behaviour only the bench scenarios can show:

- that the right nibble and bit position is decoded for a given channel;
- that a clear touches only the ones written;
- that a coincident event beats a clear of the same bit;
- that unmapped addresses stay inert.

// File: rtl/dma_irq_collect.sv
module dma_irq_collect #(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_CH-1:0] ev_half,
  input  logic [NUM_CH-1:0] ev_desc,
  input  logic [NUM_CH-1:0] ev_list,
  output logic              irq
);
  localparam int CPR     = DATA_W / 4;
  localparam int NREG    = (NUM_CH + CPR - 1) / CPR;
  localparam int ST_BASE = 'h10;

  logic [NUM_CH-1:0] en_half, en_desc, en_list;
  logic [NUM_CH-1:0] st_half, st_desc, st_list;
  logic [NREG-1:0]   wr_en_word, wr_st_word;

  for (genvar r = 0; r < NREG; r++) begin : g_dec
    assign wr_en_word[r] = reg_wr_en && (reg_addr == ADDR_W'(4 * r));
    assign wr_st_word[r] = reg_wr_en && (reg_addr == ADDR_W'(ST_BASE + 4 * r));
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int R = n / CPR;
    localparam int S = 4 * (n % CPR);
    logic [2:0] clr;
    assign clr = wr_st_word[R] ? reg_wdata[S +: 3] : 3'b000;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        {en_list[n], en_desc[n], en_half[n]} <= '0;
        {st_list[n], st_desc[n], st_half[n]} <= '0;
      end else begin
        if (wr_en_word[R])
          {en_list[n], en_desc[n], en_half[n]} <= reg_wdata[S +: 3];
        st_half[n] <= ev_half[n] | (st_half[n] & ~clr[0]);
        st_desc[n] <= ev_desc[n] | (st_desc[n] & ~clr[1]);
        st_list[n] <= ev_list[n] | (st_list[n] & ~clr[2]);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (reg_addr == ADDR_W'(4 * (n / CPR)))
        reg_rdata[4 * (n % CPR) +: 3] = {en_list[n], en_desc[n], en_half[n]};
      else if (reg_addr == ADDR_W'(ST_BASE + 4 * (n / CPR)))
        reg_rdata[4 * (n % CPR) +: 3] = {st_list[n], st_desc[n], st_half[n]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else irq <= |((st_half & en_half) | (st_desc & en_desc) | (st_list & en_list));
  end
endmodule

module dma_irq_collect_chk #(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NUM_CH-1:0] ev_half,
  input logic [NUM_CH-1:0] ev_desc,
  input logic [NUM_CH-1:0] ev_list,
  input logic [NUM_CH-1:0] st_half,
  input logic [NUM_CH-1:0] st_desc,
  input logic [NUM_CH-1:0] st_list,
  input logic [NUM_CH-1:0] en_half,
  input logic [NUM_CH-1:0] en_desc,
  input logic [NUM_CH-1:0] en_list,
  input logic              irq
);
  localparam int CPR  = DATA_W / 4;
  localparam int NREG = (NUM_CH + CPR - 1) / CPR;

  logic hit_en, hit_st;
  logic [DATA_W-1:0] rsv_mask;
  always_comb begin
    hit_en = 1'b0;
    hit_st = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      if (reg_addr == ADDR_W'(4 * r)) hit_en = reg_wr_en;
      if (reg_addr == ADDR_W'('h10 + 4 * r)) hit_st = reg_wr_en;
    end
    rsv_mask = '0;
    for (int b = 0; b < CPR; b++) rsv_mask[4 * b + 3] = 1'b1;
  end

  logic [3*NUM_CH-1:0] st_all, en_all, ev_all;
  assign st_all = {st_list, st_desc, st_half};
  assign en_all = {en_list, en_desc, en_half};
  assign ev_all = {ev_list, ev_desc, ev_half};

  assert_pend_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_all & ~$past(st_all)) & ~$past(ev_all)) == '0);

  assert_event_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_all & $past(ev_all)) == $past(ev_all));

  assert_pend_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(st_all) & ~st_all)) |-> $past(hit_st));

  assert_en_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_all) |-> $past(hit_en));

  assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & rsv_mask) == '0);

  assert_irq_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(st_all & en_all)));
endmodule

bind dma_irq_collect dma_irq_collect_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .ev_half(ev_half), .ev_desc(ev_desc), .ev_list(ev_list),
  .st_half(st_half), .st_desc(st_desc), .st_list(st_list),
  .en_half(en_half), .en_desc(en_desc), .en_list(en_list), .irq(irq)
);

// File: tb/dma_irq_collect_bench.sv
module dma_irq_collect_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] ev_half = '0, ev_desc = '0, ev_list = '0;
  logic        irq;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_irq_collect u_dma_irq_collect (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_half(ev_half),
    .ev_desc(ev_desc), .ev_list(ev_list), .irq(irq)
  );

  // reference model
  logic [2:0] m_en [16];
  logic [2:0] m_st [16];
  logic       m_irq;

  always @(posedge clk) begin
    bit acc;
    acc = 0;
    for (int n = 0; n < 16; n++) acc = acc | (|(m_st[n] & m_en[n]));
    if (!rst_n) begin
      for (int n = 0; n < 16; n++) begin m_en[n] <= 3'b0; m_st[n] <= 3'b0; end
      m_irq <= 1'b0;
    end else begin
      for (int n = 0; n < 16; n++) begin
        logic [2:0] field, clr;
        field = reg_wdata[4 * (n % 8) +: 3];
        clr = (reg_wr_en && reg_addr == 8'(8'h10 + 4 * (n / 8))) ? field : 3'b0;
        if (reg_wr_en && reg_addr == 8'(4 * (n / 8))) m_en[n] <= field;
        m_st[n] <= (m_st[n] & ~clr) | {ev_list[n], ev_desc[n], ev_half[n]};
      end
      m_irq <= acc;
    end
  end

  function automatic logic [31:0] model_read(logic [7:0] a);
    logic [31:0] v = '0;
    for (int n = 0; n < 16; n++) begin
      if (a == 8'(4 * (n / 8))) v[4 * (n % 8) +: 3] = m_en[n];
      else if (a == 8'(8'h10 + 4 * (n / 8))) v[4 * (n % 8) +: 3] = m_st[n];
    end
    return v;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      compared++;
      if (irq !== m_irq) begin
        mismatched++;
        $display("FAIL R8 irq: actual %b expected %b at %0t", irq, m_irq, $time);
      end
    end
  end

  task automatic cycle(input bit wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [15:0] h, input logic [15:0] ds, input logic [15:0] l);
    reg_wr_en = wr; reg_addr = a; reg_wdata = d;
    ev_half = h; ev_desc = ds; ev_list = l;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 0; ev_half = '0; ev_desc = '0; ev_list = '0;
  endtask

  task automatic check_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_wr_en = 0; reg_addr = a;
    #1;
    compared++;
    if (reg_rdata !== exp || exp !== model_read(a)) begin
      mismatched++;
      $display("FAIL %s addr %h: actual %h expected %h (model %h)", tag, a, reg_rdata, exp, model_read(a));
    end
  endtask

  task automatic check_irq(input bit exp, input string tag);
    compared++;
    if (irq !== exp) begin
      mismatched++;
      $display("FAIL %s irq: actual %b expected %b", tag, irq, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R10 reset state
    check_rd(8'h00, 32'h0, "R10");
    check_rd(8'h04, 32'h0, "R10");
    check_rd(8'h10, 32'h0, "R10");
    check_rd(8'h14, 32'h0, "R10");
    check_irq(0, "R10");
    // R3 / R7 enable readback, reserved bit dropped
    cycle(1, 8'h00, 32'hFFFF_FFFF, '0, '0, '0);
    check_rd(8'h00, 32'h7777_7777, "R3_R7");
    check_rd(8'h04, 32'h0, "R3");
    // R1 / R2 / R4 half event on channel 3 -> word 0x10 bit 12
    cycle(0, 8'h00, 0, 16'h0008, '0, '0);
    check_rd(8'h10, 32'h0000_1000, "R1_R2_R4");
    @(negedge clk);
    check_irq(1, "R8");
    // R4 chain-done on channel 9 with its enable clear -> word 0x14 bit 6
    cycle(0, 8'h00, 0, '0, '0, 16'h0200);
    check_rd(8'h14, 32'h0000_0040, "R4_R1");
    // R2 descriptor-done on channel 15 -> word 0x14 bit 29
    cycle(0, 8'h00, 0, '0, 16'h8000, '0);
    check_rd(8'h14, 32'h2000_0040, "R2");
    // R5 clear channel 3 half only
    cycle(1, 8'h10, 32'h0000_1000, '0, '0, '0);
    check_rd(8'h10, 32'h0, "R5");
    check_rd(8'h14, 32'h2000_0040, "R5");
    // R6 event and clear on channel 5 desc bit (bit 21) at once
    cycle(1, 8'h10, 32'h0020_0000, '0, 16'h0020, '0);
    check_rd(8'h10, 32'h0020_0000, "R6");
    // R9 zeros to pending and writes to unmapped addresses
    cycle(1, 8'h14, 32'h0, '0, '0, '0);
    check_rd(8'h14, 32'h2000_0040, "R9");
    cycle(1, 8'h08, 32'hFFFF_FFFF, '0, '0, '0);
    cycle(1, 8'h20, 32'hFFFF_FFFF, '0, '0, '0);
    check_rd(8'h08, 32'h0, "R9");
    check_rd(8'h00, 32'h7777_7777, "R9");
    check_rd(8'h04, 32'h0, "R9");
    // R7 reserved bit ignored on pending write
    cycle(1, 8'h14, 32'h8888_8888, '0, '0, '0);
    check_rd(8'h14, 32'h2000_0040, "R7");
    // R8 masking: enable ch9 then zero both enable words
    cycle(1, 8'h04, 32'h0000_0040, '0, '0, '0);
    @(negedge clk);
    check_irq(1, "R8");
    cycle(1, 8'h00, 32'h0, '0, '0, '0);
    cycle(1, 8'h04, 32'h0, '0, '0, '0);
    @(negedge clk);
    check_irq(0, "R8");
    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      case ($urandom_range(0, 4))
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h10; 3: a = 8'h14; default: a = 8'h0C;
      endcase
      cycle($urandom_range(0, 2) == 0, a, $urandom,
            16'($urandom) & 16'($urandom), 16'($urandom) & 16'($urandom),
            16'($urandom) & 16'($urandom));
      check_rd(8'h10, model_read(8'h10), "R4_R5_R6");
      check_rd(8'h14, model_read(8'h14), "R4_R5_R6");
      check_rd(8'h04, model_read(8'h04), "R3");
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule